// File: doc/BRIEF.md
# SIMD Lane Execution Mask Controller

This block decides which of the 64 lanes of a vector unit execute while the unit runs structured if/else code. A sequencer sends it one mask command per cycle, together with the per-lane result of a vector compare. The block keeps the live execution mask and a stack of saved masks, so divergent branches can nest.

On an if command, the lanes whose condition bit is clear are switched off. On an else command, the lanes that were switched off, among those saved before the if, are switched on again. The restore command puts the saved mask back. After each if or else command the block raises a one-cycle skip flag when no lane is left running, so the sequencer can branch over a body that no lane would execute. Each per-lane write enable follows its execution mask bit, so switched-off lanes never write results. Stack misuse sets a sticky error flag.

Top module: `lane_mask_ctrl`

## Requirements
- R1: After reset, all 64 mask bits and all write enables are 1, both skip flags are 0, err_o is 0, and the stack holds nothing.
- R2: Command code 1 (save) pushes the current mask onto the stack and leaves the mask unchanged.
- R3: Command code 2 (if) sets the mask, at the next clock edge, to cond_i AND the current mask. The stack is unchanged.
- R4: skip_if_o is 1 in the cycle after an if command exactly when the new mask is all zero. It is 0 in the cycle after any other command.
- R5: Command code 3 (else), with the stack not empty, sets the mask to the top stack entry AND NOT the current mask. The entry is not removed.
- R6: skip_else_o is 1 in the cycle after an else command exactly when the new mask is all zero. It is 0 in the cycle after any other command, including an else that underflows.
- R7: Command code 4 (restore), with the stack not empty, loads the mask from the top entry and removes that entry.
- R8: The stack holds up to 8 masks in last-in, first-out order.
- R9: A save with 8 entries held, or an else or restore with no entry held, sets err_o. The mask and the stack stay unchanged. err_o stays 1 until reset.
- R10: lane_we_o equals exec_mask_o in every cycle. Command codes 0, 5, 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Mask command: 0 none, 1 save, 2 if, 3 else, 4 restore |
| cond_i | input | 64 | Per-lane compare result |
| exec_mask_o | output | 64 | Current execution mask |
| lane_we_o | output | 64 | Per-lane write enable |
| skip_if_o | output | 1 | The if body has no active lane |
| skip_else_o | output | 1 | The else body has no active lane |
| err_o | output | 1 | Sticky stack overflow or underflow |

## Verification
Every result is held in a register. The mask, the two skip flags and the error flag all show the effect of a command one clock edge after the command is presented. The write enables follow the mask in the same cycle. The bench drives each command on the falling edge and advances its reference model once per rising edge. It then compares all outputs one time step after that rising edge, the first point where the registered results are valid. Nested sections, all-off and all-on compares, a full stack, underflow and a long random command stream are all compared this way.

// File: rtl/lmc_pkg.sv
package lmc_pkg;
  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_SAVE = 3'd1,
    CMD_IF   = 3'd2,
    CMD_ELSE = 3'd3,
    CMD_REST = 3'd4
  } lmc_cmd_e;
endpackage

// File: rtl/lmc_stack.sv
module lmc_stack #(
  parameter int WIDTH = 64,
  parameter int DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] top_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [CW-1:0]    cnt_q;
  logic [CW-1:0]    cnt_m1;

  assign cnt_m1  = cnt_q - 1'b1;
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign top_o   = empty_o ? '0 : mem_q[cnt_m1[AW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (push_i && !full_o) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (pop_i && !empty_o) begin
      cnt_q <= cnt_m1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[g] <= '0;
      end else if (push_i && !full_o && cnt_q == CW'(g)) begin
        mem_q[g] <= data_i;
      end
    end
  end
endmodule

// File: rtl/lmc_mask_unit.sv
module lmc_mask_unit
  import lmc_pkg::*;
#(
  parameter int LANES = 64
) (
  input  lmc_cmd_e         cmd_i,
  input  logic [LANES-1:0] cond_i,
  input  logic [LANES-1:0] exec_i,
  input  logic [LANES-1:0] top_i,
  input  logic             empty_i,
  input  logic             full_i,
  output logic [LANES-1:0] exec_d_o,
  output logic             push_o,
  output logic             pop_o,
  output logic             sif_d_o,
  output logic             selse_d_o,
  output logic             err_set_o
);
  always_comb begin
    exec_d_o  = exec_i;
    push_o    = 1'b0;
    pop_o     = 1'b0;
    sif_d_o   = 1'b0;
    selse_d_o = 1'b0;
    err_set_o = 1'b0;
    unique case (cmd_i)
      CMD_SAVE: begin
        if (full_i) err_set_o = 1'b1;
        else        push_o    = 1'b1;
      end
      CMD_IF: begin
        exec_d_o = cond_i & exec_i;
        sif_d_o  = ~|(cond_i & exec_i);
      end
      CMD_ELSE: begin
        if (empty_i) begin
          err_set_o = 1'b1;
        end else begin
          exec_d_o  = top_i & ~exec_i;
          selse_d_o = ~|(top_i & ~exec_i);
        end
      end
      CMD_REST: begin
        if (empty_i) begin
          err_set_o = 1'b1;
        end else begin
          exec_d_o = top_i;
          pop_o    = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lane_mask_ctrl.sv
module lane_mask_ctrl
  import lmc_pkg::*;
#(
  parameter int LANES = 64,
  parameter int DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       cmd_i,
  input  logic [LANES-1:0] cond_i,
  output logic [LANES-1:0] exec_mask_o,
  output logic [LANES-1:0] lane_we_o,
  output logic             skip_if_o,
  output logic             skip_else_o,
  output logic             err_o
);
  logic [LANES-1:0] exec_q, exec_d, top;
  logic push, pop, full, empty, sif_d, selse_d, err_set;
  logic sif_q, selse_q, err_q;
  lmc_cmd_e cmd;

  assign cmd = lmc_cmd_e'(cmd_i);

  lmc_mask_unit #(.LANES(LANES)) u_unit (
    .cmd_i    (cmd),
    .cond_i   (cond_i),
    .exec_i   (exec_q),
    .top_i    (top),
    .empty_i  (empty),
    .full_i   (full),
    .exec_d_o (exec_d),
    .push_o   (push),
    .pop_o    (pop),
    .sif_d_o  (sif_d),
    .selse_d_o(selse_d),
    .err_set_o(err_set)
  );

  lmc_stack #(.WIDTH(LANES), .DEPTH(DEPTH)) u_stack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .pop_i  (pop),
    .data_i (exec_q),
    .top_o  (top),
    .full_o (full),
    .empty_o(empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exec_q  <= '1;
      sif_q   <= 1'b0;
      selse_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      exec_q  <= exec_d;
      sif_q   <= sif_d;
      selse_q <= selse_d;
      err_q   <= err_q | err_set;
    end
  end

  assign exec_mask_o = exec_q;
  assign lane_we_o   = exec_q;
  assign skip_if_o   = sif_q;
  assign skip_else_o = selse_q;
  assign err_o       = err_q;
endmodule

// File: rtl/lmc_checker.sv
module lmc_checker #(
  parameter int LANES = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       cmd_i,
  input logic [LANES-1:0] cond_i,
  input logic [LANES-1:0] exec_mask_o,
  input logic [LANES-1:0] lane_we_o,
  input logic             skip_if_o,
  input logic             skip_else_o,
  input logic             err_o,
  input logic [LANES-1:0] top,
  input logic             empty
);
  always_comb begin
    AST_WE_FOLLOWS: assert (lane_we_o == exec_mask_o); // R10
  end

  AST_IF_AND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == 3'd2 |=> exec_mask_o == ($past(cond_i) & $past(exec_mask_o))); // R3

  AST_IF_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == 3'd2 |=> skip_if_o == (exec_mask_o == '0)); // R4

  AST_ELSE_ANDN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd3 && !empty) |=> exec_mask_o == ($past(top) & ~$past(exec_mask_o))); // R5

  AST_ELSE_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd3 && !empty) |=> skip_else_o == (exec_mask_o == '0)); // R6

  AST_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd4 && !empty) |=> exec_mask_o == $past(top)); // R7

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R9

  AST_NOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd0 || cmd_i > 3'd4) |=> $stable(exec_mask_o) && !skip_if_o && !skip_else_o); // R10
endmodule

bind lane_mask_ctrl lmc_checker #(.LANES(LANES)) u_lmc_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_i      (cmd_i),
  .cond_i     (cond_i),
  .exec_mask_o(exec_mask_o),
  .lane_we_o  (lane_we_o),
  .skip_if_o  (skip_if_o),
  .skip_else_o(skip_else_o),
  .err_o      (err_o),
  .top        (top),
  .empty      (empty)
);

// File: tb/lane_mask_ctrl_bench.sv
`timescale 1ns/1ps
module lane_mask_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmd = '0;
  logic [63:0] cond = '0;
  logic [63:0] exec_o, we_o;
  logic        sif_o, selse_o, err_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [63:0] m_exec;
  logic [63:0] m_stk [$];
  logic        m_sif, m_selse, m_err;

  always #10 clk = ~clk;

  lane_mask_ctrl u_lane_mask_ctrl (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .cmd_i      (cmd),
    .cond_i     (cond),
    .exec_mask_o(exec_o),
    .lane_we_o  (we_o),
    .skip_if_o  (sif_o),
    .skip_else_o(selse_o),
    .err_o      (err_o)
  );

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic compare_all(string tag);
    chk({tag, " mask"}, exec_o, m_exec);
    chk("R10 we", we_o, m_exec);
    chk({"R4 ", tag, " skip_if"}, 64'(sif_o), 64'(m_sif));
    chk({"R6 ", tag, " skip_else"}, 64'(selse_o), 64'(m_selse));
    chk({"R9 ", tag, " err"}, 64'(err_o), 64'(m_err));
  endtask

  task automatic step(logic [2:0] c, logic [63:0] cv, string tag);
    @(negedge clk);
    cmd  = c;
    cond = cv;
    m_sif   = 1'b0;
    m_selse = 1'b0;
    case (c)
      3'd1: if (m_stk.size() == 8) m_err = 1'b1; else m_stk.push_back(m_exec);
      3'd2: begin m_exec = cv & m_exec; m_sif = (m_exec == 0); end
      3'd3: if (m_stk.size() == 0) m_err = 1'b1;
            else begin m_exec = m_stk[$] & ~m_exec; m_selse = (m_exec == 0); end
      3'd4: if (m_stk.size() == 0) m_err = 1'b1; else m_exec = m_stk.pop_back();
      default: ;
    endcase
    @(posedge clk);
    #1;
    compare_all(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cmd = '0;
    m_exec = '1; m_stk.delete(); m_sif = 0; m_selse = 0; m_err = 0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    compare_all("R1 reset");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    do_reset();
    // R3/R5/R7 simple if/else
    step(3'd1, '0, "R2 save");
    step(3'd2, 64'h00FF_00FF_F0F0_1234, "R3 if");
    step(3'd3, '0, "R5 else");
    step(3'd4, '0, "R7 restore");
    // R4 all-off compare
    step(3'd1, '0, "R2 save");
    step(3'd2, '0, "R3 if all off");
    step(3'd3, '0, "R5 else all on");
    step(3'd4, '0, "R7 restore");
    // R6 all-on compare
    step(3'd1, '0, "R2 save");
    step(3'd2, '1, "R3 if all on");
    step(3'd3, '0, "R6 else empty");
    step(3'd0, '0, "R10 nop clears flags");
    step(3'd4, '0, "R7 restore");
    // R10 unused codes ignored
    step(3'd5, 64'h1, "R10 code5");
    step(3'd7, 64'h1, "R10 code7");
    // R8 nest 8 deep then overflow
    for (int i = 0; i < 8; i++) begin
      step(3'd1, '0, "R8 push");
      step(3'd2, ~(64'h1 << i), "R8 if");
    end
    step(3'd1, '0, "R9 overflow");
    for (int i = 0; i < 8; i++) step(3'd4, '0, "R8 pop");
    do_reset();
    step(3'd4, '0, "R9 underflow restore");
    step(3'd2, 64'hAAAA, "R9 still sticky");
    do_reset();
    step(3'd3, '0, "R9 underflow else");
    do_reset();
    // random stream
    for (int i = 0; i < 3000; i++) begin
      logic [2:0]  c;
      logic [63:0] v;
      c = 3'($urandom_range(0, 5));
      v = {$urandom, $urandom} | {$urandom, $urandom};
      if (($urandom & 7) == 0) v = '0;
      if (i % 700 == 0) do_reset();
      step(c, v, "R8 random");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule